// File: doc/BRIEF.md
# Port-Mapped Peripheral Decoder for an 8-bit Soft Processor

This block sits on the I/O port bus of a small 8-bit soft processor. The processor presents a port number, an output byte and a write pulse. The block decides which of three targets the access belongs to: a 64-word by 8-bit scratch memory, an 8-bit holding register or a single-bit flag. On a write cycle it updates that target. On every cycle it returns the addressed target's value on the input bus.

Only the top one or two port bits are decoded, so the space is split as follows:

- Ports 0 to 63 (top two bits 00) reach the memory.
- Ports 64 to 127 (top two bits 01) all reach the register.
- Ports 128 to 255 (top bit 1) all reach the flag.

This aliasing is intended. It keeps the decoder down to a couple of gates. Software may use any address inside a range.

Read data is combinational from the port number and the stored state. The processor therefore sees the value in the same cycle the port number is presented.

Top module: `pio_decoder`

## Requirements
- R1: With port bits [7:6] equal to 00, the memory is selected and port bits [5:0] choose the word. A strobed write stores the output byte in that word, and a later read of the same port returns it.
- R2: With port bits [7:6] equal to 01, the register is selected regardless of port bits [5:0]. A write at any port from 64 to 127 is read back identically at every port from 64 to 127.
- R3: With port bit 7 equal to 1, the flag is selected regardless of port bits [6:0]. A write stores bit 0 of the output byte, and bits [7:1] of that byte have no effect.
- R4: A target changes only at a clock edge where its decode condition holds and the write strobe is 1. The following leave all three targets unchanged:
  - an access without the strobe;
  - a write that decodes to a different target.
- R5: The input bus returns:
  - the memory word for port bits [7:6] = 00;
  - the register for 01;
  - for any port with bit 7 set, zeros in bits [7:1] and the flag in bit 0.
- R6: Reset clears the register and the flag to 0. Memory contents are not altered by reset.
- R7: The input bus depends combinationally on the port number. During a write cycle it shows the target's old value, and the new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| port_sel | input | 8 | Port number from the processor |
| wr_data | input | 8 | Output byte from the processor |
| wr_stb | input | 1 | Write pulse, one cycle per output access |
| rd_data | output | 8 | Input byte to the processor |

## Verification
A write and a read of the same target fall in the same cycle, because the input bus is always driven from the port number that the write is using. The bench checks the input bus in the middle of every strobed cycle, before the edge, and expects the old contents there. It then reads the same location, or an alias of it, in the next cycle and expects the new contents. A closing sweep over all 256 ports compares every read against a reference model of the address map, so a write that reached the wrong target, or aliasing that is missing, shows up as a mismatch.

// File: rtl/pio_decoder.sv
module pio_decoder #(
  parameter int DW     = 8,
  parameter int MEM_AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MEM_AW+1:0] port_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_stb,
  output logic [DW-1:0] rd_data
);
  localparam int PW    = MEM_AW + 2;
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] reg_q;
  logic          flag_q;

  logic [MEM_AW-1:0] word_addr;
  logic sel_mem, sel_reg, sel_flag;

  assign word_addr = port_sel[MEM_AW-1:0];
  assign sel_mem   = (port_sel[PW-1:PW-2] == 2'b00);
  assign sel_reg   = (port_sel[PW-1:PW-2] == 2'b01);
  assign sel_flag  = port_sel[PW-1];

  always_ff @(posedge clk)
    if (wr_stb && sel_mem) mem[word_addr] <= wr_data;

  always_ff @(posedge clk)
    if (rst)                  reg_q <= '0;
    else if (wr_stb && sel_reg) reg_q <= wr_data;

  always_ff @(posedge clk)
    if (rst)                   flag_q <= 1'b0;
    else if (wr_stb && sel_flag) flag_q <= wr_data[0];

  always_comb begin
    rd_data = '0;
    if (sel_flag)     rd_data[0] = flag_q;
    else if (sel_reg) rd_data = reg_q;
    else              rd_data = mem[word_addr];
  end
endmodule

// File: rtl/pio_decoder_chk.sv
module pio_decoder_chk #(
  parameter int DW     = 8,
  parameter int MEM_AW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [MEM_AW+1:0] port_sel,
  input logic [DW-1:0]     wr_data,
  input logic              wr_stb,
  input logic [DW-1:0]     rd_data,
  input logic [DW-1:0]     reg_q,
  input logic              flag_q
);
  localparam int PW = MEM_AW + 2;

  p_mem_wr_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && port_sel[PW-1:PW-2] == 2'b00) |=>
      (port_sel != $past(port_sel) || rd_data == $past(wr_data)));

  p_reg_rd_r2: assert property (@(posedge clk) disable iff (rst)
    (port_sel[PW-1:PW-2] == 2'b01) |-> rd_data == reg_q);

  p_flag_wr_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && port_sel[PW-1]) |=> flag_q == $past(wr_data[0]));

  p_reg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && port_sel[PW-1:PW-2] == 2'b01) |=> $stable(reg_q));

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && port_sel[PW-1]) |=> $stable(flag_q));

  p_flag_zext_r5: assert property (@(posedge clk) disable iff (rst)
    port_sel[PW-1] |-> (rd_data[DW-1:1] == '0 && rd_data[0] == flag_q));
endmodule

bind pio_decoder pio_decoder_chk #(.DW(DW), .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst(rst), .port_sel(port_sel), .wr_data(wr_data),
  .wr_stb(wr_stb), .rd_data(rd_data), .reg_q(reg_q), .flag_q(flag_q)
);

// File: tb/test_pio_decoder.sv
module test_pio_decoder;
  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] port_sel = 0;
  logic [7:0] wr_data = 0;
  logic       wr_stb = 0;
  logic [7:0] rd_data;

  pio_decoder i_pio_decoder (
    .clk(clk), .rst(rst), .port_sel(port_sel), .wr_data(wr_data),
    .wr_stb(wr_stb), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] port;
    string      tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] m_mem [64];
  logic [7:0] m_reg;
  logic       m_flag;

  function automatic logic [7:0] model_rd(input logic [7:0] p);
    if (p[7])             return {7'b0, m_flag};
    if (p[6])             return m_reg;
    return m_mem[p[5:0]];
  endfunction

  // monitor: checks every item in the cycle it was driven
  initial forever begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (rd_data !== it.exp) begin
        bad++;
        $display("FAIL %s port=%0d actual=%02h expected=%02h",
                 it.tag, it.port, rd_data, it.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] p, input string tag);
    item_t it;
    @(negedge clk);
    port_sel = p; wr_stb = 0; wr_data = 8'h5a;
    it.exp = model_rd(p); it.port = p; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] p, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    port_sel = p; wr_data = d; wr_stb = 1;
    it.exp = model_rd(p); it.port = p; it.tag = "R7 old value during write";
    q.push_back(it);
    @(posedge clk);
    if (p[7])      m_flag = d[0];
    else if (p[6]) m_reg = d;
    else           m_mem[p[5:0]] = d;
  endtask

  task automatic nostb(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    port_sel = p; wr_data = d; wr_stb = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_stb = 0; rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_reg = 0; m_flag = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_reg = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    rd(8'd64,  "R6 register cleared by reset");
    rd(8'd200, "R6 flag cleared by reset");

    for (int i = 0; i < 64; i++) wr(i[7:0], 8'(i * 7 + 3));
    for (int i = 0; i < 64; i++) rd(i[7:0], "R1 memory readback");

    wr(8'd81, 8'ha5);
    rd(8'd64,  "R2 register alias 64");
    rd(8'd100, "R2 register alias 100");
    rd(8'd127, "R2 register alias 127");
    rd(8'd17,  "R4 memory untouched by register write");

    wr(8'h80, 8'hff);
    rd(8'd255, "R3 flag alias 255");
    rd(8'h93,  "R5 flag zero extended");
    rd(8'd70,  "R4 register untouched by flag write");

    wr(8'hc4, 8'hfe);
    rd(8'd129, "R3 only bit 0 stored");
    wr(8'hc4, 8'h01);

    nostb(8'd90, 8'h33);
    nostb(8'd5, 8'h44);
    nostb(8'd150, 8'h00);
    rd(8'd90,  "R4 register held without strobe");
    rd(8'd5,   "R4 memory held without strobe");
    rd(8'd150, "R4 flag held without strobe");

    wr(8'd10, 8'h3c);
    rd(8'd10,  "R1 memory rewrite");
    rd(8'd120, "R4 register untouched by memory write");
    rd(8'd240, "R4 flag untouched by memory write");

    do_reset();
    rd(8'd99,  "R6 register cleared by reset");
    rd(8'd133, "R6 flag cleared by reset");
    rd(8'd10,  "R6 memory kept across reset");
    rd(8'd63,  "R6 memory kept across reset");

    wr(8'd66, 8'h96);
    wr(8'hff, 8'h03);
    for (int a = 0; a < 256; a++) rd(a[7:0], "R5 full map sweep");

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule